// File: doc/BRIEF.md
# APB Register Bank Completer

This block answers APB3/APB4 transfers on behalf of a small bank of 32-bit storage registers. The requester addresses the bank with byte addresses: word register n answers at byte offset 4·n. Writes merge new data into the selected word one byte lane at a time, under control of the strobe bits. Reads return the stored word in the cycle where the transfer completes.

Every Access phase is stretched by a fixed, parameter-set number of wait states. Several accesses get a defined error response instead of undefined behaviour: an address that is not word aligned, an address past the last register, and, when the privilege check is enabled, a write issued without privileged protection. Read data and the error flag are held at zero in every cycle except the completing one.

Top module: `apb_regbank`

## Requirements
- R1: Register n is reached at byte address 4·n. A read that completes without error returns the value most recently stored in that register.
- R2: On a write that completes without error, byte lane b (data bits 8b+7 down to 8b) of the addressed register takes the new write data only when strobe bit b is 1. Lanes whose strobe bit is 0 keep their old value.
- R3: With select and enable both high, ready stays low for WAIT_CYCLES consecutive Access cycles and goes high on the next cycle. Ready is low whenever select or enable is low.
- R4: An access whose address bits [1:0] are not 00 completes with the error flag high. If it is a read, the read data is zero.
- R5: An access whose word index (address bits above bit 1) is NUM_REGS or more completes with the error flag high.
- R6: A write that completes with the error flag high leaves every register unchanged.
- R7: When PRIV_CHECK is 1, a write with protection bit 0 equal to 0 (normal, not privileged) completes with the error flag high. Reads are served whatever the protection value.
- R8: Read data and the error flag are zero in every cycle except the completing cycle (select, enable and ready all high). Read data is also zero in the completing cycle of a write.
- R9: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every state change happens on its rising edge |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Completer select |
| enable | input | 1 | High during the Access phase |
| write | input | 1 | 1 for a write, 0 for a read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| strb | input | 4 | Byte-lane write strobes, bit b enables lane b |
| prot | input | 3 | Protection attributes; bit 0 = 1 marks a privileged access |
| rdata | output | 32 | Read data, nonzero only in the completing cycle of a read |
| ready | output | 1 | Ends the Access phase when high |
| slverr | output | 1 | Error response, valid in the completing cycle |

## Verification
A wrong wait-state count shows up on the first transfer after reset, because ready rises one cycle early or late. A corrupted byte lane, or a write that should have been dropped but was not, stays hidden until that register is read back. So every write vector in the stimulus table is followed by a read of the same or a neighbouring register. A decode fault shows up in the completing cycle of the offending access, either as a missing error flag or as read data leaking out of that cycle.

// File: rtl/apb_regbank_pkg.sv
package apb_regbank_pkg;

    typedef enum logic [1:0] {
        ACC_OK       = 2'd0,
        ACC_MISALIGN = 2'd1,
        ACC_RANGE    = 2'd2,
        ACC_PRIV     = 2'd3
    } acc_status_e;

endpackage

// File: rtl/apb_regbank_decode.sv
module apb_regbank_decode
    import apb_regbank_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_REGS   = 8,
    parameter int IDX_W      = 3,
    parameter bit PRIV_CHECK = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [2:0]        prot,
    output logic [IDX_W-1:0]  idx,
    output acc_status_e       status
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_REGS);

    logic [WORD_W-1:0] word;

    assign word = addr[ADDR_W-1:2];
    assign idx  = word[IDX_W-1:0];

    always_comb begin
        if (addr[1:0] != 2'b00) begin
            status = ACC_MISALIGN;
        end else if (word >= LIMIT) begin
            status = ACC_RANGE;
        end else if (PRIV_CHECK && write && !prot[0]) begin
            status = ACC_PRIV;
        end else begin
            status = ACC_OK;
        end
    end
endmodule

// File: rtl/apb_regbank_waitgen.sv
module apb_regbank_waitgen #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic ready
);
    generate
        if (WAIT_CYCLES == 0) begin : g_nowait
            assign ready = access;
        end else begin : g_wait
            localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES);

            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } wstate_t;

            wstate_t st_d, st_q;

            assign ready = access && (st_q.cnt == LAST);

            always_comb begin
                st_d = st_q;
                if (access && !ready) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end else begin
                    st_d.cnt = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/apb_regbank_store.sv
module apb_regbank_store #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] strb,
    output logic [DATA_W-1:0]   rword
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (strb[b]) begin
                    regs_d[idx][8*b +: 8] = wdata[8*b +: 8];
                end
            end
        end
    end

    always_comb begin
        rword = '0;
        if (int'(idx) < NUM_REGS) begin
            rword = regs_q[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                regs_q[r] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank
    import apb_regbank_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_REGS    = 8,
    parameter int WAIT_CYCLES = 2,
    parameter bit PRIV_CHECK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        strb,
    input  logic [2:0]        prot,
    output logic [31:0]       rdata,
    output logic              ready,
    output logic              slverr
);
    localparam int DATA_W = 32;
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              access;
    logic              done;
    logic              fault;
    logic              wr_en;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rword;
    acc_status_e       status;

    assign access = sel && enable;
    assign done   = access && ready;
    assign fault  = (status != ACC_OK);
    assign wr_en  = done && write && !fault;

    apb_regbank_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W),
        .PRIV_CHECK(PRIV_CHECK)
    ) u_decode (
        .addr  (addr),
        .write (write),
        .prot  (prot),
        .idx   (idx),
        .status(status)
    );

    apb_regbank_waitgen #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_waitgen (
        .clk   (clk),
        .rst_n (rst_n),
        .access(access),
        .ready (ready)
    );

    apb_regbank_store #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .idx  (idx),
        .wdata(wdata),
        .strb (strb),
        .rword(rword)
    );

    assign slverr = done && fault;
    assign rdata  = (done && !write && !fault) ? rword : '0;
endmodule

// File: rtl/apb_regbank_chk.sv
module apb_regbank_chk #(
    parameter int ADDR_W      = 12,
    parameter int NUM_REGS    = 8,
    parameter int WAIT_CYCLES = 2,
    parameter bit PRIV_CHECK  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              enable,
    input logic              write,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [3:0]        strb,
    input logic [2:0]        prot,
    input logic [31:0]       rdata,
    input logic              ready,
    input logic              slverr
);
    int  stall_q;
    logic fin;

    assign fin = sel && enable && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q <= 0;
        end else if (sel && enable && !ready) begin
            stall_q <= stall_q + 1;
        end else begin
            stall_q <= 0;
        end
    end

    assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && enable) |-> !ready);

    assert_wait_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (stall_q == WAIT_CYCLES));

    assert_misalign_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && addr[1:0] != 2'b00) |-> (slverr && rdata == 32'h0));

    assert_range_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && int'(addr >> 2) >= NUM_REGS) |-> slverr);

    assert_priv_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (PRIV_CHECK && fin && write && !prot[0]) |-> slverr);

    assert_err_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slverr |-> fin);

    assert_rdata_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata != 32'h0) |-> (fin && !write));

    logic unused_ok;
    assign unused_ok = ^{wdata, strb, prot[2:1]};
endmodule

bind apb_regbank apb_regbank_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .WAIT_CYCLES(WAIT_CYCLES),
    .PRIV_CHECK (PRIV_CHECK)
) u_chk (.*);

// File: tb/apb_regbank_test.sv
module apb_regbank_test;
    localparam int ADDR_W  = 12;
    localparam int NREGS   = 8;
    localparam int NWAIT   = 2;
    localparam int NVEC    = 16;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  strb;
        logic [2:0]  prot;
        logic [31:0] exp_rdata;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    // req field: requirement number the vector targets
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 12'h000, 32'h11223344, 4'hF, 3'b001, 32'h0,        1'b0, 4'd1},
        '{1'b0, 12'h000, 32'h0,        4'h0, 3'b001, 32'h11223344, 1'b0, 4'd1},
        '{1'b1, 12'h004, 32'hAABBCCDD, 4'h5, 3'b001, 32'h0,        1'b0, 4'd2},
        '{1'b0, 12'h004, 32'h0,        4'h0, 3'b001, 32'h00BB00DD, 1'b0, 4'd2},
        '{1'b1, 12'h004, 32'hFFFFFFFF, 4'hA, 3'b001, 32'h0,        1'b0, 4'd2},
        '{1'b0, 12'h004, 32'h0,        4'h0, 3'b001, 32'hFFBBFFDD, 1'b0, 4'd2},
        '{1'b1, 12'h01C, 32'h5A5A5A5A, 4'hF, 3'b001, 32'h0,        1'b0, 4'd1},
        '{1'b0, 12'h01C, 32'h0,        4'h0, 3'b001, 32'h5A5A5A5A, 1'b0, 4'd1},
        '{1'b1, 12'h002, 32'hDEADBEEF, 4'hF, 3'b001, 32'h0,        1'b1, 4'd4},
        '{1'b0, 12'h000, 32'h0,        4'h0, 3'b001, 32'h11223344, 1'b0, 4'd6},
        '{1'b0, 12'h003, 32'h0,        4'h0, 3'b001, 32'h0,        1'b1, 4'd4},
        '{1'b1, 12'h020, 32'hCAFEF00D, 4'hF, 3'b001, 32'h0,        1'b1, 4'd5},
        '{1'b0, 12'h020, 32'h0,        4'h0, 3'b001, 32'h0,        1'b1, 4'd5},
        '{1'b1, 12'h008, 32'h12345678, 4'hF, 3'b000, 32'h0,        1'b1, 4'd7},
        '{1'b0, 12'h008, 32'h0,        4'h0, 3'b000, 32'h0,        1'b0, 4'd6},
        '{1'b0, 12'h01C, 32'h0,        4'h0, 3'b000, 32'h5A5A5A5A, 1'b0, 4'd7}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              enable = 1'b0;
    logic              write = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [3:0]        strb = '0;
    logic [2:0]        prot = '0;
    logic [31:0]       rdata;
    logic              ready;
    logic              slverr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    apb_regbank #(
        .ADDR_W     (ADDR_W),
        .NUM_REGS   (NREGS),
        .WAIT_CYCLES(NWAIT),
        .PRIV_CHECK (1'b1)
    ) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .enable(enable),
        .write (write),
        .addr  (addr),
        .wdata (wdata),
        .strb  (strb),
        .prot  (prot),
        .rdata (rdata),
        .ready (ready),
        .slverr(slverr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer; called right after a rising edge (+1 ns)
    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic [2:0] p,
                        output logic [31:0] rd, output logic er, output int waits);
        sel = 1'b1; enable = 1'b0; write = wr; addr = a; wdata = d; strb = s; prot = p;
        #1;
        check(ready == 1'b0, "R3 ready low in setup", 32'(ready), 32'h0);
        check(rdata == 32'h0 && slverr == 1'b0, "R8 idle outputs in setup",
              rdata | 32'(slverr), 32'h0);
        @(posedge clk); #1;
        enable = 1'b1;
        waits = 0;
        #1;
        while (!ready && waits < 64) begin
            check(rdata == 32'h0 && slverr == 1'b0, "R8 idle outputs in wait state",
                  rdata | 32'(slverr), 32'h0);
            @(posedge clk); #2;
            waits++;
        end
        rd = rdata;
        er = slverr;
        @(posedge clk); #1;
        sel = 1'b0; enable = 1'b0; write = 1'b0;
        #1;
        check(ready == 1'b0 && slverr == 1'b0 && rdata == 32'h0, "R3 R8 outputs after transfer",
              rdata | 32'(ready) | 32'(slverr), 32'h0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          w;
        repeat (3) @(posedge clk);
        #1;
        check(ready == 1'b0 && slverr == 1'b0 && rdata == 32'h0, "R8 outputs in reset",
              rdata | 32'(ready) | 32'(slverr), 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R9: every register is zero after reset
        for (int i = 0; i < NREGS; i++) begin
            xfer(1'b0, 12'(4 * i), 32'h0, 4'h0, 3'b001, rd, er, w);
            check(rd == 32'h0 && !er, "R9 register cleared by reset", rd, 32'h0);
            check(w == NWAIT, "R3 wait states", 32'(w), 32'(NWAIT));
        end

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            xfer(VECS[v].wr, VECS[v].addr, VECS[v].wdata, VECS[v].strb, VECS[v].prot,
                 rd, er, w);
            check(rd == VECS[v].exp_rdata, $sformatf("R%0d vector %0d read data", VECS[v].req, v),
                  rd, VECS[v].exp_rdata);
            check(er == VECS[v].exp_err, $sformatf("R%0d vector %0d error flag", VECS[v].req, v),
                  32'(er), 32'(VECS[v].exp_err));
            check(w == NWAIT, "R3 wait states per transfer", 32'(w), 32'(NWAIT));
        end

        // R6: out-of-range and privilege-failed writes touched nothing
        for (int i = 2; i < NREGS - 1; i++) begin
            xfer(1'b0, 12'(4 * i), 32'h0, 4'h0, 3'b001, rd, er, w);
            check(rd == 32'h0, "R6 untouched register stays zero", rd, 32'h0);
        end

        // R8: write completion keeps read data zero even with data stored
        xfer(1'b1, 12'h00C, 32'h0F0F0F0F, 4'hF, 3'b011, rd, er, w);
        check(rd == 32'h0 && !er, "R8 read data zero on write completion", rd, 32'h0);
        xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'b110, rd, er, w);
        check(rd == 32'h0F0F0F0F, "R1 R7 read with normal protection", rd, 32'h0F0F0F0F);

        // R2: zero strobe writes nothing
        xfer(1'b1, 12'h00C, 32'hFFFFFFFF, 4'h0, 3'b001, rd, er, w);
        xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'b001, rd, er, w);
        check(rd == 32'h0F0F0F0F, "R2 empty strobe keeps word", rd, 32'h0F0F0F0F);

        // R9: reset in mid-run clears stored data
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        xfer(1'b0, 12'h01C, 32'h0, 4'h0, 3'b001, rd, er, w);
        check(rd == 32'h0, "R9 reset clears register 7", rd, 32'h0);
        xfer(1'b0, 12'h00C, 32'h0, 4'h0, 3'b001, rd, er, w);
        check(rd == 32'h0, "R9 reset clears register 3", rd, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule